// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Overrun Lock

This block receives asynchronous serial words on a single line. A frame is a low start bit, then 8 data bits sent least significant bit first (9 when the nine-bit mode is on), then a high stop bit. Each finished word is copied from the shift stage into a two-entry first-in first-out buffer. Each entry also stores the word's ninth bit and its framing-error status. The consumer reads the head entry on `data_o`, `ninth_o` and `ferr_o`. A one-cycle `rd_i` pulse removes the head. Because the pop moves all three fields at once, the status bits must be taken before the data is popped.

The line is oversampled on a tick that comes every `div_i + 1` clocks. A bit lasts 16 ticks with `fast_i` high and 4 ticks with it low. Each bit is decided by a two-of-three vote near its centre. If a third word completes while both entries are full, that word is dropped and the sticky overrun flag is raised. The receiver then stays idle until the continuous-receive enable is lowered, which is also the only way to clear the flag.

Top module: `async_rx`

## Requirements
- R1: Words are received only while `port_en_i` and `rcv_en_i` are both 1. A frame sent while either is 0 leaves `avail_o` at 0.
- R2: The oversample tick comes every `div_i + 1` clocks. A bit lasts 16 ticks when `fast_i` = 1 and 4 ticks when `fast_i` = 0.
- R3: A frame is start (0), then data bits least significant bit first, then stop (1). The head word's low 8 bits appear on `data_o`.
- R4: With `nine_en_i` = 1 a ninth data bit is taken after bit 7 and shown on `ninth_o`. With `nine_en_i` = 0, `ninth_o` is 0.
- R5: Each bit is decided by a majority of three samples at ticks mid-1, mid and mid+1, where mid is half the bit length. A start bit whose vote is 1 is dropped as a glitch.
- R6: A word whose stop bit votes 0 is stored with `ferr_o` = 1. After such a word the receiver waits for the line to go high before it looks for a new start.
- R7: `avail_o` is 1 whenever the buffer holds a word. `irq_o` equals `avail_o` AND `irq_en_i`.
- R8: The buffer holds two words in arrival order. `rd_i` removes the head entry with its data, ninth bit and framing flag together. `rd_i` on an empty buffer has no effect.
- R9: A word that completes while the buffer is full and not being read sets `oerr_o` and is discarded. While `oerr_o` is 1, no new word enters the buffer, and the words already in it stay readable.
- R10: `oerr_o` stays 1 until `rcv_en_i` is 0. One clock with `rcv_en_i` low clears it.
- R11: After reset, `avail_o`, `irq_o`, `oerr_o`, `ferr_o`, `ninth_o` and `data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| div_i | input | 8 | Tick divisor; tick period is div_i+1 clocks |
| fast_i | input | 1 | 1: 16 ticks per bit, 0: 4 ticks per bit |
| port_en_i | input | 1 | Serial port enable |
| rcv_en_i | input | 1 | Continuous-receive enable; low clears overrun |
| nine_en_i | input | 1 | Nine-bit word mode |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Pop the head buffer entry |
| data_o | output | 8 | Head word, bits 7..0 |
| ninth_o | output | 1 | Head word, ninth bit |
| ferr_o | output | 1 | Head word framing error |
| oerr_o | output | 1 | Sticky overrun error |
| avail_o | output | 1 | Receive-complete flag: buffer not empty |
| irq_o | output | 1 | Receive interrupt |

## Verification
A word reaches the buffer a few clocks after the middle tick of its stop bit: two synchroniser stages, one shift-stage register and one buffer register. The bench therefore samples `avail_o`, the head fields and `oerr_o` only after the stop bit and two more idle bit periods have passed. A pop or an enable change shows at the outputs one clock after the edge that takes it. So every check after `rd_i` or `rcv_en_i` is made on the falling edge that follows the next rising edge.

// File: rtl/arx_pkg.sv
// Shared constants and the buffer entry type for the serial receiver.
// Assumes OS_FAST and OS_SLOW are even and OS_FAST >= OS_SLOW >= 4.
package arx_pkg;
    localparam int DATA_W    = 8;
    localparam int DIV_W     = 8;
    localparam int OS_FAST   = 16;
    localparam int OS_SLOW   = 4;
    localparam int BUF_DEPTH = 2;

    typedef struct packed {
        logic              ferr;
        logic [DATA_W:0]   word;
    } arx_entry_t;
endpackage

// File: rtl/arx_baud.sv
// Oversample tick generator: one-clock tick every div_i+1 clocks while run_i.
// Assumes div_i is held steady while a frame is in progress.
module arx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    assign tick_o = run_i && (cnt == '0);

    // Count down from the divisor and reload on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt <= '0;
        else if (cnt == '0)   cnt <= div_i;
        else                  cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/arx_shift.sv
// Frame sampler and shift stage. Finds the start edge, votes 2-of-3 around
// each bit centre, and pulses done_o once the stop bit is decided.
// Assumes rx_i is already synchronised to clk and tick_i comes from arx_baud.
module arx_shift
    import arx_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          tick_i,
    input  logic          fast_i,
    input  logic          nine_i,
    input  logic          rx_i,
    output logic          done_o,
    output logic          err_o,
    output logic [DW:0]   word_o
);
    localparam int POS_W = $clog2(OS_FAST);
    localparam int BI_W  = $clog2(DW + 1);

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_WAITHI} st_t;
    st_t st;

    logic [POS_W-1:0] pos, mid, mid_m, mid_p, last;
    logic [BI_W-1:0]  bi, blast;
    logic             s0, s1, vote;
    logic [DW:0]      sh;

    assign mid   = fast_i ? POS_W'(OS_FAST / 2) : POS_W'(OS_SLOW / 2);
    assign mid_m = mid - 1'b1;
    assign mid_p = mid + 1'b1;
    assign last  = fast_i ? POS_W'(OS_FAST - 1) : POS_W'(OS_SLOW - 1);
    assign blast = nine_i ? BI_W'(DW) : BI_W'(DW - 1);
    assign vote  = (s0 & s1) | (s0 & rx_i) | (s1 & rx_i);
    assign word_o = sh;

    // Frame state machine: bit position, sample capture and word assembly.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            st <= S_IDLE; pos <= '0; bi <= '0;
            s0 <= 1'b1; s1 <= 1'b1; sh <= '0;
            done_o <= 1'b0; err_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                unique case (st)
                    S_IDLE: if (!rx_i) begin
                        st <= S_START; pos <= '0; bi <= '0; sh <= '0;
                    end
                    S_WAITHI: if (rx_i) st <= S_IDLE;
                    default: begin
                        if (pos == last) begin
                            pos <= '0;
                            if (st == S_START) st <= S_DATA;
                            else if (st == S_DATA && bi == blast) st <= S_STOP;
                            else if (st == S_DATA) bi <= bi + 1'b1;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                        if (pos == mid_m) s0 <= rx_i;
                        if (pos == mid)   s1 <= rx_i;
                        if (pos == mid_p) begin
                            if (st == S_START && vote) st <= S_IDLE;
                            else if (st == S_DATA) sh[bi] <= vote;
                            else if (st == S_STOP) begin
                                done_o <= 1'b1;
                                err_o  <= !vote;
                                st     <= vote ? S_IDLE : S_WAITHI;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6
    ferr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o && active_i) |-> (st == S_WAITHI));
endmodule

// File: rtl/arx_buf.sv
// First-in first-out receive buffer. The head entry is shown combinationally.
// A push while full is accepted only together with a pop.
module arx_buf #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_pop, do_push;

    assign empty_o = (cnt == '0);
    assign full_o  = (cnt == CW'(DEPTH));
    assign do_pop  = pop_i && !empty_o;
    assign do_push = push_i && (!full_o || do_pop);
    assign dout_o  = mem[rp];

    // One storage entry per slot, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) mem[g] <= '0;
            else if (do_push && wp == AW'(g)) mem[g] <= din_i;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // R8
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (cnt == $past(cnt) - 1'b1));
    // R8
    push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> !empty_o);
endmodule

// File: rtl/async_rx.sv
// Asynchronous serial receiver top. It synchronises the line, runs the tick
// generator and the shift stage, stores words in a two-entry buffer, and
// holds the sticky overrun flag that blocks reception until rcv_en_i drops.
module async_rx
    import arx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             fast_i,
    input  logic             port_en_i,
    input  logic             rcv_en_i,
    input  logic             nine_en_i,
    input  logic             irq_en_i,
    input  logic             rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic             ninth_o,
    output logic             ferr_o,
    output logic             oerr_o,
    output logic             avail_o,
    output logic             irq_o
);
    localparam int EW = $bits(arx_entry_t);

    logic [1:0]      rx_sync;
    logic            active, tick, done, err, empty, full, pop;
    logic [DATA_W:0] word;
    arx_entry_t      head, wr_ent;

    assign active  = port_en_i && rcv_en_i && !oerr_o;
    assign pop     = rd_i && !empty;
    assign wr_ent  = '{ferr: err, word: word};
    assign data_o  = head.word[DATA_W-1:0];
    assign ninth_o = head.word[DATA_W];
    assign ferr_o  = head.ferr;
    assign avail_o = !empty;
    assign irq_o   = avail_o && irq_en_i;

    // Two-stage synchroniser for the serial line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], rx_i};
    end

    // Sticky overrun: set by a word that finds no room, cleared by rcv_en_i low.
    always_ff @(posedge clk) begin
        if (!rst_n || !rcv_en_i)        oerr_o <= 1'b0;
        else if (done && full && !pop) oerr_o <= 1'b1;
    end

    arx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run_i(active), .div_i(div_i), .tick_o(tick)
    );

    arx_shift #(.DW(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .active_i(active), .tick_i(tick),
        .fast_i(fast_i), .nine_i(nine_en_i), .rx_i(rx_sync[1]),
        .done_o(done), .err_o(err), .word_o(word)
    );

    arx_buf #(.W(EW), .DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .push_i(done), .pop_i(rd_i),
        .din_i(wr_ent), .dout_o(head), .empty_o(empty), .full_o(full)
    );

    // R9
    oerr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oerr_o) |-> $past(full));
    // R10
    oerr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oerr_o && rcv_en_i) |=> oerr_o);
    // R10
    oerr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rcv_en_i |=> !oerr_o);
    // R9
    oerr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oerr_o && !rd_i) |=> (avail_o == $past(avail_o)));
endmodule

// File: tb/tb_async_rx.sv
module tb_async_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [7:0] div = 8'd1;
    logic       fast = 1'b1, port_en = 1'b0, rcv_en = 1'b0, nine = 1'b0;
    logic       irq_en = 1'b0, rd = 1'b0;
    logic [7:0] data;
    logic       ninth, ferr, oerr, avail, irq;
    int         total = 0, fails = 0;

    always #4 clk = ~clk;

    async_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .div_i(div), .fast_i(fast),
        .port_en_i(port_en), .rcv_en_i(rcv_en), .nine_en_i(nine),
        .irq_en_i(irq_en), .rd_i(rd), .data_o(data), .ninth_o(ninth),
        .ferr_o(ferr), .oerr_o(oerr), .avail_o(avail), .irq_o(irq)
    );

    // Vector: {fast, nine, stop_ok, data[8:0]}
    localparam logic [11:0] VEC [6] = '{
        {1'b1, 1'b0, 1'b1, 9'h0A5},
        {1'b1, 1'b1, 1'b1, 9'h13C},
        {1'b0, 1'b1, 1'b1, 9'h0FF},
        {1'b0, 1'b0, 1'b1, 9'h100},
        {1'b1, 1'b0, 1'b0, 9'h05A},
        {1'b0, 1'b1, 1'b0, 9'h1C3}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int bitlen();
        return (int'(div) + 1) * (fast ? 16 : 4);
    endfunction

    // Send one frame; glitch flips the line for 2 clocks at the centre of bit 0.
    task automatic send(input logic [8:0] d, input logic stop_ok, input logic glitch);
        int bl = bitlen();
        int nb = nine ? 9 : 8;
        @(posedge clk); #1;
        rx = 1'b0; clks(bl);
        for (int i = 0; i < nb; i++) begin
            rx = d[i];
            if (i == 0 && glitch) begin
                clks(bl / 2); rx = ~d[0]; clks(2); rx = d[0]; clks(bl - bl / 2 - 2);
            end else clks(bl);
        end
        rx = stop_ok; clks(bl);
        rx = 1'b1; clks(2 * bl);
        @(negedge clk);
    endtask

    task automatic pop();
        @(posedge clk); #1 rd = 1'b1;
        @(posedge clk); #1 rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        clks(4); rst_n = 1'b1; @(negedge clk);
        // R11 reset state
        chk("R11 avail", avail, 0); chk("R11 oerr", oerr, 0);
        chk("R11 ferr", ferr, 0);   chk("R11 irq", irq, 0);
        chk("R11 data", data, 0);   chk("R11 ninth", ninth, 0);

        port_en = 1'b1; rcv_en = 1'b1;
        // R3 R4 R6 table walk
        for (int v = 0; v < 6; v++) begin
            fast = VEC[v][11]; nine = VEC[v][10];
            send(VEC[v][8:0], VEC[v][9], 1'b0);
            chk("R3 avail", avail, 1);
            chk("R3 data", data, VEC[v][7:0]);
            chk("R4 ninth", ninth, nine ? VEC[v][8] : 1'b0);
            chk("R6 ferr", ferr, !VEC[v][9]);
            pop();
            chk("R8 empty after pop", avail, 0);
        end

        fast = 1'b1; nine = 1'b0;
        // R7 interrupt gating
        send(9'h033, 1'b1, 1'b0);
        chk("R7 irq masked", irq, 0);
        irq_en = 1'b1; #1;
        chk("R7 irq enabled", irq, 1);
        pop();
        chk("R7 irq after pop", irq, 0);

        // R8 read on empty ignored
        pop();
        send(9'h011, 1'b1, 1'b0);
        chk("R8 data after empty read", data, 8'h11);
        pop();
        chk("R8 single entry", avail, 0);

        // R1 enables
        rcv_en = 1'b0; send(9'h0C3, 1'b1, 1'b0);
        chk("R1 rcv_en off", avail, 0);
        rcv_en = 1'b1; port_en = 1'b0; send(9'h0C3, 1'b1, 1'b0);
        chk("R1 port_en off", avail, 0);
        port_en = 1'b1;

        // R5 start glitch rejected, data glitch voted out
        @(posedge clk); #1 rx = 1'b0; clks(6); rx = 1'b1; clks(3 * bitlen());
        @(negedge clk);
        chk("R5 start glitch", avail, 0);
        send(9'h0B6, 1'b1, 1'b1);
        chk("R5 vote data", data, 8'hB6);
        pop();

        // R9 overrun, R8 order
        send(9'h0A1, 1'b1, 1'b0); send(9'h0A2, 1'b1, 1'b0);
        chk("R9 no oerr at two", oerr, 0);
        send(9'h0A3, 1'b1, 1'b0);
        chk("R9 oerr set", oerr, 1);
        chk("R8 head first", data, 8'hA1);
        pop();
        chk("R8 head second", data, 8'hA2);
        pop();
        chk("R9 third discarded", avail, 0);
        send(9'h0A4, 1'b1, 1'b0);
        chk("R9 blocked while oerr", avail, 0);
        chk("R10 oerr held", oerr, 1);
        @(posedge clk); #1 rcv_en = 1'b0;
        @(posedge clk); #1 rcv_en = 1'b1;
        @(negedge clk);
        chk("R10 oerr cleared", oerr, 0);
        send(9'h0A5, 1'b1, 1'b0);
        chk("R10 receive resumes", data, 8'hA5);
        pop();

        // R2 other divisor and slow ratio
        div = 8'd3; fast = 1'b0;
        send(9'h06E, 1'b1, 1'b0);
        chk("R2 div3 slow data", data, 8'h6E);
        pop();
        div = 8'd0; fast = 1'b1;
        send(9'h091, 1'b1, 1'b0);
        chk("R2 div0 fast data", data, 8'h91);
        pop();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule